// File: doc/BRIEF.md
# Six-Channel ADC Read and Conversion-Start Sequencer

This block connects a signal processor's asynchronous external memory bus to six parallel-output successive-approximation converters that share the processor's data bus through a level translator. The block has no data path. It watches the bus select, the read strobe and a 3-bit word address, and from these it produces an active-low chip select and an active-low read/convert strobe for each converter. It also drives the translator's output enables.

A read of a channel address enables exactly one converter and opens the translator. During this read every read/convert line stays high, so no conversion can start by accident. A finished read of the last channel, or of either of the two spare address codes, starts a conversion round. A status flag rises, all chip selects and read/convert lines then go low together for a fixed number of clocks, and everything returns high. A spare-address read therefore acts as a start command without a write strobe.

All bus inputs pass through a two-stage synchronizer. The end of a read is taken from the synchronized deassertion of the read cycle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all six chip selects and all six read/convert lines are high, both translator enables are high (disabled), and the round flag is low.
- R2: While bus select and read strobe are both low and the round flag is low at the start of the read, address code k (0 to 5) drives chip select bit k low and keeps the other five high. The select appears on the third clock edge after the inputs change.
- R3: All read/convert lines stay high for as long as any single chip select is low for a read.
- R4: Both translator enables (active low) are low exactly while a channel is selected for a read, and high otherwise.
- R5: When an accepted read of address code 5 ends, the round flag rises on the third clock edge after the read strobe rises. One clock later all chip selects and read/convert lines go low together for 2 clocks. Then all of them go high and the flag falls in the same cycle.
- R6: A read of spare address code 6 or 7 selects no converter and leaves the translator disabled. When that read ends, it starts the same round as R5.
- R7: Reads of address codes 0 to 4 never start a round.
- R8: A read that begins while the round flag is high selects no converter and keeps the translator disabled for its whole length, even after the flag falls. When it ends it starts no round, even at address code 5.
- R9: A read strobe with bus select high selects nothing and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (30 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Bus region select from the processor, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_addr | input | 3 | Word address code: 0 to 5 are channels, 6 and 7 are start commands |
| adc_cs_n | output | 6 | Per-converter chip select, active low |
| adc_rc_n | output | 6 | Per-converter read/convert strobe, active low |
| xlat_oe_n | output | 2 | Level translator output enables, active low |
| round_flag | output | 1 | High while a conversion start round is in progress |

## Verification
Each result has a fixed latency. Two synchronizer stages and one registered decode stage mean that a select or a translator enable follows an input change on the third rising edge. The round flag also rises on the third edge after the read strobe rises. The start pulse covers edges four and five, and everything is released on edge six. The bench drives inputs on falling edges, counts rising edges from that point, and samples on the falling edge after the edge where each result is due. It checks every cycle of the start round, so a pulse that comes one cycle early, comes one cycle late, or runs short is reported.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int ADC_CH = 6;
  localparam int ADDR_W = 3;
  localparam int OE_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GUARD = 2'd1,
    ST_START = 2'd2
  } round_st_t;

  // Address codes at or above the channel count are start commands.
  function automatic logic is_spare(input logic [ADDR_W-1:0] a);
    return a >= ADDR_W'(ADC_CH);
  endfunction

  function automatic logic is_last(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(ADC_CH - 1);
  endfunction

  function automatic logic [ADC_CH-1:0] chan_onehot(input logic [ADDR_W-1:0] a);
    logic [ADC_CH-1:0] r;
    r = '0;
    if (!is_spare(a)) r = ADC_CH'(1) << a;
    return r;
  endfunction

  function automatic logic starts_round(input logic [ADDR_W-1:0] a);
    return is_last(a) || is_spare(a);
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rd_decode.sv
module rd_decode
  import adc_seq_pkg::*;
#(
  parameter int NCH = ADC_CH,
  parameter int AW  = ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_sel_n,
  input  logic           s_rd_n,
  input  logic [AW-1:0]  s_addr,
  input  logic           busy,
  output logic [NCH-1:0] sel_oh,
  output logic           rd_done,
  output logic [AW-1:0]  done_addr
);
  logic           rd_active, act_q, rd_start, rd_end;
  logic           acc_q;
  logic [AW-1:0]  addr_q;
  logic [NCH-1:0] sel_q, sel_d;

  assign rd_active = !s_sel_n && !s_rd_n;
  assign rd_start  = rd_active && !act_q;
  assign rd_end    = !rd_active && act_q;

  always_comb begin
    sel_d = '0;
    if (rd_active) begin
      if (rd_start) sel_d = busy ? '0 : NCH'(chan_onehot(s_addr));
      else          sel_d = sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      acc_q  <= 1'b0;
      addr_q <= '0;
      sel_q  <= '0;
    end else begin
      act_q <= rd_active;
      sel_q <= sel_d;
      if (rd_start) begin
        acc_q  <= !busy;
        addr_q <= s_addr;
      end
    end
  end

  assign sel_oh    = sel_q;
  assign rd_done   = rd_end && acc_q;
  assign done_addr = addr_q;

  // R2: at most one converter selected
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  // R8: a read opening during a round is refused
  a_r8_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && busy) |=> (sel_q == '0));

  // R9: no selection without an active read cycle
  a_r9_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> (sel_q == '0));
endmodule

// File: rtl/start_timer.sv
module start_timer
  import adc_seq_pkg::*;
#(
  parameter int GUARD_CYC = 1,
  parameter int HOLD_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic busy,
  output logic pulse
);
  localparam int CW = $clog2(GUARD_CYC + HOLD_CYC + 1);

  round_st_t      st_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (trigger) st_q <= ST_GUARD;
        end
        ST_GUARD: begin
          if (cnt_q == CW'(GUARD_CYC - 1)) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_START: begin
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign pulse = (st_q == ST_START);

  // R5: start pulse lasts at least two clocks
  a_r5_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |=> pulse);

  // R5: pulse only inside a flagged round
  a_r5_pulse_in_round: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> busy);

  // R5: end of pulse ends the round
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> !busy);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 1,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_rd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADC_CH-1:0] adc_cs_n,
  output logic [ADC_CH-1:0] adc_rc_n,
  output logic [OE_W-1:0]   xlat_oe_n,
  output logic              round_flag
);
  localparam int SW = ADDR_W + 2;

  logic [SW-1:0]     sync_in, sync_out;
  logic              s_sel_n, s_rd_n;
  logic [ADDR_W-1:0] s_addr;
  logic [ADC_CH-1:0] sel_oh;
  logic              rd_done, busy, pulse, trigger;
  logic [ADDR_W-1:0] done_addr;

  assign sync_in = {bus_sel_n, bus_rd_n, bus_addr};

  bus_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({2'b11, {ADDR_W{1'b0}}})
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_out)
  );

  assign {s_sel_n, s_rd_n, s_addr} = sync_out;

  rd_decode #(.NCH(ADC_CH), .AW(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .s_sel_n(s_sel_n), .s_rd_n(s_rd_n), .s_addr(s_addr),
    .busy(busy),
    .sel_oh(sel_oh), .rd_done(rd_done), .done_addr(done_addr)
  );

  assign trigger = rd_done && starts_round(done_addr);

  start_timer #(.GUARD_CYC(GUARD_CYC), .HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .busy(busy), .pulse(pulse)
  );

  assign adc_cs_n   = ~(sel_oh | {ADC_CH{pulse}});
  assign adc_rc_n   = ~{ADC_CH{pulse}};
  assign xlat_oe_n  = {OE_W{~|sel_oh}};
  assign round_flag = busy;

  // R3: read/convert stays high while a converter is read
  a_r3_rc_quiet_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_oh) |-> (&adc_rc_n));

  // R4: translator never open during a round
  a_r4_no_oe_in_round: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_oh) |-> !busy);

  // R7: rounds only follow a finished read
  a_r7_round_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rd_done));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel_n = 1'b1;
  logic       bus_rd_n = 1'b1;
  logic [2:0] bus_addr = 3'd0;
  logic [5:0] adc_cs_n, adc_rc_n;
  logic [1:0] xlat_oe_n;
  logic       round_flag;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
    .bus_addr(bus_addr), .adc_cs_n(adc_cs_n), .adc_rc_n(adc_rc_n),
    .xlat_oe_n(xlat_oe_n), .round_flag(round_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance n rising edges, then sit on the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic begin_read(input logic seln, input logic [2:0] a);
    @(negedge clk);
    bus_sel_n = seln; bus_addr = a; bus_rd_n = 1'b0;
  endtask

  // called on a falling edge: releases the strobe there
  task automatic end_read_now();
    bus_rd_n = 1'b1;
  endtask

  // verify a full round after the strobe release at the current falling edge
  task automatic expect_round(input string tag);
    step(2);
    chk({tag, " flag still low before edge 3"}, 16'(round_flag), 16'd0);
    step(1);
    chk({tag, " flag up"}, 16'(round_flag), 16'd1);
    chk({tag, " guard cs high"}, 16'(adc_cs_n), 16'h3f);
    step(1);
    chk({tag, " pulse cs"}, 16'(adc_cs_n), 16'h00);
    chk({tag, " pulse rc"}, 16'(adc_rc_n), 16'h00);
    chk({tag, " pulse oe off"}, 16'(xlat_oe_n), 16'h3);
    step(1);
    chk({tag, " pulse cycle 2"}, 16'({adc_cs_n, adc_rc_n}), 16'h000);
    step(1);
    chk({tag, " release"}, 16'({adc_cs_n, adc_rc_n}), 16'hfff);
    chk({tag, " flag down"}, 16'(round_flag), 16'd0);
    bus_sel_n = 1'b1;
  endtask

  task automatic expect_quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      step(1);
      chk({tag, " no round"}, 16'({round_flag, adc_rc_n}), 16'h03f);
    end
  endtask

  task automatic t_reset();
    chk("R1 cs", 16'(adc_cs_n), 16'h3f);
    chk("R1 rc", 16'(adc_rc_n), 16'h3f);
    chk("R1 oe", 16'(xlat_oe_n), 16'h3);
    chk("R1 flag", 16'(round_flag), 16'd0);
  endtask

  task automatic t_channel(input int k);
    begin_read(1'b0, 3'(k));
    step(2);
    chk("R2 not before edge 3", 16'(adc_cs_n), 16'h3f);
    step(1);
    chk("R2 one select", 16'(adc_cs_n), 16'(~(6'b1 << k) & 6'h3f));
    chk("R3 rc high in read", 16'(adc_rc_n), 16'h3f);
    chk("R4 oe open", 16'(xlat_oe_n), 16'h0);
    step(2);
    chk("R3 rc high later", 16'(adc_rc_n), 16'h3f);
    end_read_now();
    if (k == 5) begin
      expect_round("R5");
    end else begin
      step(3);
      chk("R4 oe closed", 16'(xlat_oe_n), 16'h3);
      chk("R2 select dropped", 16'(adc_cs_n), 16'h3f);
      bus_sel_n = 1'b1;
      expect_quiet("R7", 5);
    end
  endtask

  task automatic t_spare(input logic [2:0] a);
    begin_read(1'b0, a);
    step(3);
    chk("R6 spare no select", 16'(adc_cs_n), 16'h3f);
    chk("R6 spare oe closed", 16'(xlat_oe_n), 16'h3);
    step(1);
    end_read_now();
    expect_round("R6");
  endtask

  task automatic t_busy_read();
    begin_read(1'b0, 3'd5);
    step(4);
    end_read_now();
    @(negedge clk);
    bus_rd_n = 1'b0; bus_addr = 3'd5;
    step(2);
    chk("R8 flag up", 16'(round_flag), 16'd1);
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R8 oe closed", 16'(xlat_oe_n), 16'h3);
      if (i >= 3) chk("R8 no select", 16'(adc_cs_n), 16'h3f);
    end
    end_read_now();
    bus_sel_n = 1'b1;
    expect_quiet("R8", 6);
  endtask

  task automatic t_no_select();
    begin_read(1'b1, 3'd1);
    step(3);
    chk("R9 no select", 16'(adc_cs_n), 16'h3f);
    chk("R9 oe closed", 16'(xlat_oe_n), 16'h3);
    bus_addr = 3'd5;
    step(2);
    end_read_now();
    expect_quiet("R9", 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    for (int k = 0; k < 6; k++) t_channel(k);
    t_spare(3'd6);
    t_spare(3'd7);
    t_busy_read();
    t_no_select();
    t_channel(2);
    t_channel(5);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule